// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block configures a port of up to 32 I/O lines through a small register bus. Each line either stays under general-purpose control, where software sets its output data and direction, or is handed to one of four peripheral functions that drive its output value and output enable directly. Every line owns the same bit position in every register, and each configuration attribute (ownership, direction, output data, open-drain style multi-drive, pull-up, synchronous-write mask) is changed only through a pair of set and clear addresses. Writing 1 to a bit acts on that line, and writing 0 leaves it alone. A third address per attribute reads the current state.

A synchronous output address updates the output data of many lines in one write, limited to the lines enabled in the write mask. A two-flop synchronized copy of the pad input can always be read back, whatever mode each line is in. A keyed write-protect mode freezes the configuration. A blocked write raises a sticky violation flag and records the offset that was targeted.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every line is under general-purpose control with peripheral select code 0, direction input, output data 0, multi-drive off, write mask 0, write protect off, and pull-up enabled on every line.
- R2: Each attribute has a set address at base, a clear address at base+0x4 and a status address at base+0x8. The bases are 0x00 for general-purpose ownership, 0x10 for direction (1 = drive), 0x20 for output data, 0x30 for multi-drive, 0x40 for pull-up and 0x50 for the synchronous-write mask. A 1 bit sets or clears that line; a 0 bit leaves it unchanged.
- R3: A line under general-purpose control drives pad_out from its output data bit and pad_oe from its direction bit.
- R4: A line under peripheral control takes its value and enable from function k = {select1 bit, select0 bit}, read from bit k*N+i of per_dout and per_doe. Select0 is written and read whole at 0x60 and select1 at 0x64.
- R5: With multi-drive on, a line never drives high: pad_out is 0, and pad_oe is asserted only while the selected value is 0.
- R6: A write to 0x70 loads the write data into the output data of lines whose mask bit is 1 and leaves all other lines unchanged.
- R7: Reading 0x78 returns pad_in as sampled two clock edges earlier, in any line mode.
- R8: pad_pu follows the pull-up attribute.
- R9: A write to 0x7C sets write protect to bit 0 only when bits 31:8 equal 0x9E7A15; any other write to it is ignored. Reading 0x7C returns the enable in bit 0.
- R10: While write protect is on, writes to the set and clear addresses of every attribute except output data, and to 0x60 and 0x64, have no effect. Such a write sets the violation flag (bit 0 of 0x80) and stores its address in bits 15:8. A read of 0x80 clears both. Output data set, clear and synchronous writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; the read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data |
| per_dout | input | 4*N | Output values of the four peripheral functions, function k at bits k*N+: N |
| per_doe | input | 4*N | Output enables of the four peripheral functions, same layout |
| pad_in | input | N | Level seen on each pad |
| pad_out | output | N | Value driven to each pad |
| pad_oe | output | N | Driver enable for each pad |
| pad_pu | output | N | Pull-up enable for each pad |

## Verification
The peripheral mux is checked by giving each function a distinct one-hot bit and routing one line to each select code. A swapped select bit or a wrong function order leaves some pad low. Multi-drive is checked on two driven lines, one holding 1 and one holding 0. A design that forces the value low but keeps the driver on, or that releases both lines, fails the pad_oe check. The bench also writes out-of-mask bits to the synchronous address, reads the pin status at zero, one and two edges after a pad change, tries a write-protect enable with a wrong key, and checks that output data writes still work while protection is on. It then reads the violation record twice, so a flag that is not sticky, not cleared by the read, or that stores the wrong offset is reported.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 8;

  // attribute index; set address = index*16, clear = +4, status = +8
  typedef enum logic [2:0] {
    ATTR_GPIO = 3'd0,
    ATTR_DIR  = 3'd1,
    ATTR_OUT  = 3'd2,
    ATTR_MD   = 3'd3,
    ATTR_PU   = 3'd4,
    ATTR_OWE  = 3'd5
  } attr_e;

  localparam int unsigned NUM_ATTR = 6;

  localparam logic [ADDR_W-1:0] A_SEL0    = 8'h60;
  localparam logic [ADDR_W-1:0] A_SEL1    = 8'h64;
  localparam logic [ADDR_W-1:0] A_SYNC    = 8'h70;
  localparam logic [ADDR_W-1:0] A_PIN     = 8'h78;
  localparam logic [ADDR_W-1:0] A_WP_MODE = 8'h7C;
  localparam logic [ADDR_W-1:0] A_WP_STS  = 8'h80;

  localparam logic [23:0] WP_KEY = 24'h9E7A15;

  function automatic logic [ADDR_W-1:0] attr_addr(input int unsigned idx, input int unsigned sub);
    attr_addr = ADDR_W'(idx * 16 + sub);
  endfunction

  // addresses whose writes are frozen by write protection
  function automatic logic is_cfg_write(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == A_SEL0) || (a == A_SEL1);
    for (int k = 0; k < int'(NUM_ATTR); k++) begin
      if (k != int'(ATTR_OUT) && (a == attr_addr(k, 0) || a == attr_addr(k, 4)))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pin_q
);

  logic [N-1:0] stage1_q, stage1_d;
  logic [N-1:0] stage2_q, stage2_d;

  always_comb begin
    stage1_d = pad_in;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign pin_q = stage2_q;

  // edges since reset, saturating, so the check never reaches before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_q <= 2'd0;
    else if (warm_q != 2'd2)   warm_q <= warm_q + 2'd1;
  end

  p_pin_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (pin_q == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_port_lines.sv
module gpio_port_lines #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]   gpio_q,
  input  logic [N-1:0]   dir_q,
  input  logic [N-1:0]   out_q,
  input  logic [N-1:0]   md_q,
  input  logic [N-1:0]   sel0_q,
  input  logic [N-1:0]   sel1_q,
  input  logic [4*N-1:0] per_dout,
  input  logic [4*N-1:0] per_doe,
  output logic [N-1:0]   pad_out,
  output logic [N-1:0]   pad_oe
);

  localparam int unsigned NFUNC = 4;

  for (genvar i = 0; i < int'(N); i++) begin : g_line
    logic [NFUNC-1:0] fval, fen;
    logic [1:0]       code;
    logic             val, en;

    for (genvar k = 0; k < int'(NFUNC); k++) begin : g_fn
      assign fval[k] = per_dout[k*N + i];
      assign fen[k]  = per_doe[k*N + i];
    end

    always_comb begin
      code = {sel1_q[i], sel0_q[i]};
      if (gpio_q[i]) begin
        val = out_q[i];
        en  = dir_q[i];
      end else begin
        val = fval[code];
        en  = fen[code];
      end
      if (md_q[i]) begin
        pad_out[i] = 1'b0;
        pad_oe[i]  = en & ~val;
      end else begin
        pad_out[i] = val;
        pad_oe[i]  = en;
      end
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic [N-1:0]      pin_q,
  output logic [N-1:0]      gpio_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      md_q,
  output logic [N-1:0]      pu_q,
  output logic [N-1:0]      sel0_q,
  output logic [N-1:0]      sel1_q
);

  logic [N-1:0] wd;
  logic         blocked, wr_ok;
  logic         wp_en_q, wp_en_d, wp_we;
  logic         viol_q, viol_d;
  logic [7:0]   voff_q, voff_d;
  logic         viol_we;
  logic [N-1:0] sel0_d, sel1_d;
  logic         sel0_we, sel1_we;

  logic [NUM_ATTR-1:0][N-1:0] attr_vec;
  logic [N-1:0] owe_q;

  assign wd      = wdata[N-1:0];
  assign blocked = wr_en & wp_en_q & is_cfg_write(addr);
  assign wr_ok   = wr_en & ~blocked;

  // set/clear attribute registers
  for (genvar g = 0; g < int'(NUM_ATTR); g++) begin : g_attr
    localparam logic [ADDR_W-1:0] SET_A = attr_addr(g, 0);
    localparam logic [ADDR_W-1:0] CLR_A = attr_addr(g, 4);
    localparam logic [N-1:0] RST_V =
      (g == int'(ATTR_GPIO) || g == int'(ATTR_PU)) ? {N{1'b1}} : {N{1'b0}};
    localparam bit HAS_SYNC = (g == int'(ATTR_OUT));

    logic [N-1:0] q, d;
    logic         we;

    always_comb begin
      d  = q;
      we = 1'b0;
      if (wr_ok && addr == SET_A) begin
        d  = q | wd;
        we = 1'b1;
      end else if (wr_ok && addr == CLR_A) begin
        d  = q & ~wd;
        we = 1'b1;
      end else if (HAS_SYNC && wr_ok && addr == A_SYNC) begin
        d  = (q & ~owe_q) | (wd & owe_q);
        we = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (we) q <= d;
    end

    assign attr_vec[g] = q;
  end

  assign gpio_q = attr_vec[ATTR_GPIO];
  assign dir_q  = attr_vec[ATTR_DIR];
  assign out_q  = attr_vec[ATTR_OUT];
  assign md_q   = attr_vec[ATTR_MD];
  assign pu_q   = attr_vec[ATTR_PU];
  assign owe_q  = attr_vec[ATTR_OWE];

  // peripheral select registers, written whole
  always_comb begin
    sel0_we = wr_ok && addr == A_SEL0;
    sel1_we = wr_ok && addr == A_SEL1;
    sel0_d  = wd;
    sel1_d  = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel0_q <= '0;
      sel1_q <= '0;
    end else begin
      if (sel0_we) sel0_q <= sel0_d;
      if (sel1_we) sel1_q <= sel1_d;
    end
  end

  // write protection and violation record
  always_comb begin
    wp_we   = wr_en && addr == A_WP_MODE && wdata[31:8] == WP_KEY;
    wp_en_d = wdata[0];
    viol_we = blocked || (rd_en && addr == A_WP_STS);
    viol_d  = blocked;
    voff_d  = blocked ? 8'(addr) : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_en_q <= 1'b0;
      viol_q  <= 1'b0;
      voff_q  <= 8'h00;
    end else begin
      if (wp_we) wp_en_q <= wp_en_d;
      if (viol_we) begin
        viol_q <= viol_d;
        voff_q <= voff_d;
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int k = 0; k < int'(NUM_ATTR); k++) begin
      if (addr == attr_addr(k, 8)) rdata[N-1:0] = attr_vec[k];
    end
    case (addr)
      A_SEL0:    rdata[N-1:0] = sel0_q;
      A_SEL1:    rdata[N-1:0] = sel1_q;
      A_SYNC:    rdata[N-1:0] = out_q;
      A_PIN:     rdata[N-1:0] = pin_q;
      A_WP_MODE: rdata[0]     = wp_en_q;
      A_WP_STS:  rdata        = {16'h0000, voff_q, 7'b0, viol_q};
      default:   ;
    endcase
  end

  p_set_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == attr_addr(ATTR_DIR, 0)) |=>
      ((dir_q & $past(wd)) == $past(wd)));

  p_clr_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == attr_addr(ATTR_DIR, 4)) |=>
      ((dir_q & $past(wd)) == '0));

  p_sync_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SYNC) |=>
      (((out_q ^ $past(out_q)) & ~$past(owe_q)) == '0));

  p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_WP_MODE && wdata[31:8] != WP_KEY) |=> $stable(wp_en_q));

  p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ($stable(dir_q) && $stable(gpio_q) && $stable(md_q) &&
                 $stable(sel0_q) && $stable(sel1_q) && viol_q));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int unsigned N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_wr,
  input  logic           bus_rd,
  output logic [31:0]    bus_rdata,
  input  logic [4*N-1:0] per_dout,
  input  logic [4*N-1:0] per_doe,
  input  logic [N-1:0]   pad_in,
  output logic [N-1:0]   pad_out,
  output logic [N-1:0]   pad_oe,
  output logic [N-1:0]   pad_pu
);

  // reset asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N-1:0] pin_q, gpio_q, dir_q, out_q, md_q, pu_q, sel0_q, sel1_q;

  gpio_port_sync #(.N(N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pad_in (pad_in),
    .pin_q  (pin_q)
  );

  gpio_port_regs #(.N(N)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .rdata  (bus_rdata),
    .pin_q  (pin_q),
    .gpio_q (gpio_q),
    .dir_q  (dir_q),
    .out_q  (out_q),
    .md_q   (md_q),
    .pu_q   (pu_q),
    .sel0_q (sel0_q),
    .sel1_q (sel1_q)
  );

  gpio_port_lines #(.N(N)) u_lines (
    .gpio_q   (gpio_q),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .md_q     (md_q),
    .sel0_q   (sel0_q),
    .sel1_q   (sel1_q),
    .per_dout (per_dout),
    .per_doe  (per_doe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign pad_pu = pu_q;

  p_gpio_follow_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((gpio_q & ~md_q & (pad_out ^ out_q)) == '0));

  p_md_release_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (((md_q & pad_out) == '0) && ((md_q & gpio_q & out_q & pad_oe) == '0)));

  p_pull_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pad_pu == pu_q));

endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/100ps
module gpio_port_ctrl_test;

  localparam int unsigned N = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata;
  logic           bus_wr, bus_rd;
  logic [31:0]    bus_rdata;
  logic [4*N-1:0] per_dout, per_doe;
  logic [N-1:0]   pad_in, pad_out, pad_oe, pad_pu;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .per_dout(per_dout), .per_doe(per_doe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // scoreboard: kind 0 = read data, 1 = pad_out, 2 = pad_oe, 3 = pad_pu
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  logic  mon_go = 1'b0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  localparam logic [23:0] KEY = 24'h9E7A15;

  always @(negedge clk) begin
    if (mon_go) begin
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = pad_out;
          2:       act = pad_oe;
          default: act = pad_pu;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    it.kind = 0; it.exp = e; it.req = req;
    bus_addr = a; bus_rd = 1'b1;
    sb.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; mon_go = 1'b0;
  endtask

  task automatic pad_chk(input int kind, input logic [31:0] e, input string req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    sb.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    per_dout = '0; per_doe = '0; pad_in = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    rd_chk(8'h08, 32'hFFFF_FFFF, "R1 gpio");
    rd_chk(8'h18, 32'h0, "R1 dir");
    rd_chk(8'h28, 32'h0, "R1 out");
    rd_chk(8'h38, 32'h0, "R1 md");
    rd_chk(8'h58, 32'h0, "R1 owe");
    rd_chk(8'h60, 32'h0, "R1 sel0");
    rd_chk(8'h7C, 32'h0, "R1 wp");
    pad_chk(2, 32'h0, "R1 pad_oe");
    pad_chk(3, 32'hFFFF_FFFF, "R1 pad_pu");

    // R2 set/clear
    wr(8'h10, 32'h0000_00FF);
    wr(8'h14, 32'h0000_000F);
    rd_chk(8'h18, 32'h0000_00F0, "R2 dir set/clear");
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    rd_chk(8'h18, 32'h0000_00F0, "R2 zero write");

    // R3 gpio drive
    wr(8'h20, 32'h0000_00A0);
    pad_chk(1, 32'h0000_00A0, "R3 pad_out");
    pad_chk(2, 32'h0000_00F0, "R3 pad_oe");

    // R4 peripheral mux: lines 8..11 use functions A..D
    per_dout = {32'h0000_0800, 32'h0000_0400, 32'h0000_0200, 32'h0000_0100};
    per_doe  = {4{32'hFFFF_FF00}};
    wr(8'h04, 32'h0000_0F00);
    wr(8'h60, 32'h0000_0A00);
    wr(8'h64, 32'h0000_0C00);
    rd_chk(8'h08, 32'hFFFF_F0FF, "R4 gpio status");
    pad_chk(1, 32'h0000_0FA0, "R4 pad_out");
    pad_chk(2, 32'h0000_0FF0, "R4 pad_oe");

    // R5 multi-drive on lines 6 (value 0) and 7 (value 1)
    wr(8'h30, 32'h0000_00C0);
    pad_chk(1, 32'h0000_0F20, "R5 pad_out");
    pad_chk(2, 32'h0000_0F70, "R5 pad_oe");
    wr(8'h34, 32'h0000_00C0);

    // R6 masked synchronous write
    wr(8'h50, 32'h0000_00F0);
    wr(8'h70, 32'hFFFF_FF0F);
    rd_chk(8'h28, 32'h0, "R6 sync clear in mask");
    wr(8'h70, 32'hFFFF_0F50);
    rd_chk(8'h70, 32'h0000_0050, "R6 sync mixed");

    // R7 pin status latency
    pad_in = 32'h1234_5678;
    rd_chk(8'h78, 32'h0, "R7 zero edges");
    rd_chk(8'h78, 32'h0, "R7 one edge");
    rd_chk(8'h78, 32'h1234_5678, "R7 two edges");

    // R8 pull-ups
    wr(8'h44, 32'h0000_FFFF);
    pad_chk(3, 32'hFFFF_0000, "R8 pu clear");
    wr(8'h40, 32'h0000_0001);
    pad_chk(3, 32'hFFFF_0001, "R8 pu set");

    // R9 wrong key ignored, right key enables
    wr(8'h7C, 32'h1234_5601);
    rd_chk(8'h7C, 32'h0, "R9 bad key");
    wr(8'h10, 32'h0000_0001);
    rd_chk(8'h18, 32'h0000_00F1, "R9 still writable");
    wr(8'h7C, {KEY, 8'h01});
    rd_chk(8'h7C, 32'h1, "R9 key enable");

    // R10 protection
    wr(8'h10, 32'hF000_0000);
    rd_chk(8'h18, 32'h0000_00F1, "R10 dir frozen");
    rd_chk(8'h80, 32'h0000_1001, "R10 violation record");
    rd_chk(8'h80, 32'h0, "R10 cleared on read");
    wr(8'h64, 32'hFFFF_FFFF);
    rd_chk(8'h64, 32'h0000_0C00, "R10 sel frozen");
    rd_chk(8'h80, 32'h0000_6401, "R10 sel offset");
    wr(8'h20, 32'h0000_0001);
    rd_chk(8'h28, 32'h0000_0051, "R10 out still writable");
    wr(8'h7C, {KEY, 8'h00});
    wr(8'h10, 32'h0000_0100);
    rd_chk(8'h18, 32'h0000_01F1, "R10 unlocked");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule